// File: doc/BRIEF.md
# Multiplexed Seven-Segment Count and Mode Display

This block drives a bank of six seven-segment digits that share one set of segment lines. It lights one digit at a time. On each scan-tick strobe it hands the segment lines to the next digit. The tick is slow compared with the clock, and the scan is fast enough that the eye sees all six digits lit at once.

The three lower digit positions show a 4-bit count value. The three upper positions show a 3-bit mode code with a zero added as its top bit. The value chosen for the lit position goes through a decimal-to-segment decoder. Any code that is not a decimal digit turns all segments off.

The digit enable comes straight from the scan state, and the segment pattern is decoded from the same state in the same cycle. The two never disagree, so a digit cannot show data meant for another position. The data inputs are not registered, so a change on the count or mode shows at once on the position being displayed.

Top module: `digit_scan_driver`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the digit enable is 6'b000001 (position 0) and the segment lines show the decoded count value.
- R2: The digit enable always has exactly one bit set. Bit k of the enable selects position k.
- R3: Each clock cycle with the scan tick high moves the lit position from k to k+1. A tick at position 5 returns the scan to position 0.
- R4: In a clock cycle where the scan tick is low, the digit enable does not change.
- R5: At positions 0, 1 and 2 the segment lines show the count value.
- R6: At positions 3, 4 and 5 the segment lines show the mode code with a leading zero added, giving a value from 0 to 7.
- R7: The segment lines are active high. The segment bus is {a,b,c,d,e,f,g}, with bit 6 = a and bit 0 = g. The digits 0..9 encode as 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111 and 1111011.
- R8: Any displayed code from 10 to 15 drives all segment lines low.
- R9: The enable and the segment pattern always come from the same position. When the scan advances, the segments show the new position's data in the same cycle as its enable. A change on the count or mode input shows on the segments without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | One-cycle strobe that moves the scan to the next position |
| count_val | input | 4 | Count value shown on positions 0 to 2 |
| mode_code | input | 3 | Mode code shown on positions 3 to 5 |
| digit_en | output | 6 | One-hot digit enable, bit k = position k |
| seg_out | output | 7 | Segment lines {a,b,c,d,e,f,g}, active high |

## Verification
Two things can happen in the same clock cycle: the scan steps to a new position, and the count or mode input changes. The bench provokes this by raising the scan tick and changing the count in one drive step. At the crossings from position 2 to 3 and from 5 to 0, the new data source and the new position take effect in the same cycle. The result is correct only if the segments show the new input decoded for the new position in the cycle after the edge, and match the enable bit that is lit in that cycle.

// File: rtl/digit_scan_pkg.sv
package digit_scan_pkg;

   localparam int unsigned GLYPH_W = 7;

   typedef logic [GLYPH_W-1:0] glyph_t;

   // Bit 6 = a ... bit 0 = g, active high
   function automatic glyph_t digit_glyph(input logic [3:0] d);
      glyph_t g;
      case (d)
         4'd0:    g = 7'b1111110;
         4'd1:    g = 7'b0110000;
         4'd2:    g = 7'b1101101;
         4'd3:    g = 7'b1111001;
         4'd4:    g = 7'b0110011;
         4'd5:    g = 7'b1011011;
         4'd6:    g = 7'b1011111;
         4'd7:    g = 7'b1110000;
         4'd8:    g = 7'b1111111;
         4'd9:    g = 7'b1111011;
         default: g = '0;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/scan_ring.sv
module scan_ring #(
   parameter int unsigned NUM_POS = 6,
   localparam int unsigned IDX_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   output logic [IDX_W-1:0]   idx,
   output logic [NUM_POS-1:0] en
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_POS - 1);

   generate
      if (NUM_POS < 2) begin : g_bad
         $error("scan_ring: NUM_POS must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_d;

   always_comb begin
      idx_d = idx_q;
      if (tick) begin
         if (idx_q == LAST_IDX) idx_d = '0;
         else                   idx_d = idx_q + IDX_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx_d;
   end

   assign idx = idx_q;

   genvar p;
   generate
      for (p = 0; p < NUM_POS; p++) begin : g_en
         assign en[p] = (idx_q == IDX_W'(p));
      end
   endgenerate

endmodule

// File: rtl/pos_source_mux.sv
module pos_source_mux #(
   parameter int unsigned NUM_POS = 6,
   parameter int unsigned CNT_POS = 3,
   parameter int unsigned VAL_W   = 4,
   parameter int unsigned MODE_W  = 3,
   localparam int unsigned IDX_W  = (NUM_POS > 1) ? $clog2(NUM_POS) : 1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [VAL_W-1:0]  count,
   input  logic [MODE_W-1:0] mode,
   output logic [VAL_W-1:0]  val
);

   generate
      if (CNT_POS == 0 || CNT_POS >= NUM_POS) begin : g_bad_split
         $error("pos_source_mux: CNT_POS must be between 1 and NUM_POS-1");
      end
      if (MODE_W >= VAL_W) begin : g_bad_mode
         $error("pos_source_mux: MODE_W must be narrower than VAL_W");
      end
   endgenerate

   logic [VAL_W-1:0] pos_val [NUM_POS];
   logic [VAL_W-1:0] mode_ext;

   assign mode_ext = VAL_W'(mode);

   genvar p;
   generate
      for (p = 0; p < NUM_POS; p++) begin : g_src
         if (p < CNT_POS) begin : g_cnt
            assign pos_val[p] = count;
         end else begin : g_mode
            assign pos_val[p] = mode_ext;
         end
      end
   endgenerate

   always_comb begin
      val = '0;
      for (int i = 0; i < NUM_POS; i++) begin
         if (idx == IDX_W'(i)) val = pos_val[i];
      end
   end

endmodule

// File: rtl/glyph_decoder.sv
module glyph_decoder
   import digit_scan_pkg::*;
#(
   parameter int unsigned VAL_W = 4
) (
   input  logic [VAL_W-1:0] val,
   output glyph_t           seg
);

   localparam logic [VAL_W-1:0] MAX_DIGIT = VAL_W'(9);

   generate
      if (VAL_W < 4) begin : g_bad
         $error("glyph_decoder: VAL_W must be at least 4");
      end
   endgenerate

   always_comb begin
      if (val > MAX_DIGIT) seg = '0;
      else                 seg = digit_glyph(val[3:0]);
   end

endmodule

// File: rtl/digit_scan_driver.sv
module digit_scan_driver
   import digit_scan_pkg::*;
#(
   parameter int unsigned NUM_POS = 6,
   parameter int unsigned CNT_POS = 3,
   parameter int unsigned VAL_W   = 4,
   parameter int unsigned MODE_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scan_tick,
   input  logic [VAL_W-1:0]   count_val,
   input  logic [MODE_W-1:0]  mode_code,
   output logic [NUM_POS-1:0] digit_en,
   output logic [GLYPH_W-1:0] seg_out
);

   localparam int unsigned IDX_W = (NUM_POS > 1) ? $clog2(NUM_POS) : 1;

   logic [IDX_W-1:0] scan_idx;
   logic [VAL_W-1:0] shown_val;
   glyph_t           glyph;

   scan_ring #(.NUM_POS(NUM_POS)) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (scan_tick),
      .idx   (scan_idx),
      .en    (digit_en)
   );

   pos_source_mux #(
      .NUM_POS (NUM_POS),
      .CNT_POS (CNT_POS),
      .VAL_W   (VAL_W),
      .MODE_W  (MODE_W)
   ) u_mux (
      .idx   (scan_idx),
      .count (count_val),
      .mode  (mode_code),
      .val   (shown_val)
   );

   glyph_decoder #(.VAL_W(VAL_W)) u_dec (
      .val (shown_val),
      .seg (glyph)
   );

   assign seg_out = glyph;

endmodule

// File: rtl/digit_scan_checker.sv
module digit_scan_checker #(
   parameter int unsigned NUM_POS = 6,
   parameter int unsigned CNT_POS = 3,
   parameter int unsigned VAL_W   = 4,
   parameter int unsigned MODE_W  = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scan_tick,
   input logic [VAL_W-1:0]   count_val,
   input logic [MODE_W-1:0]  mode_code,
   input logic [NUM_POS-1:0] digit_en,
   input logic [6:0]         seg_out
);

   AST_ONE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(digit_en) == 1); // R2

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      scan_tick && !digit_en[NUM_POS-1] |=> digit_en == ($past(digit_en) << 1)); // R3

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      scan_tick && digit_en[NUM_POS-1] |=> digit_en == NUM_POS'(1)); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_tick |=> $stable(digit_en)); // R4

   AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      digit_en[0] && count_val > VAL_W'(9) |-> seg_out == 7'b0); // R8

   AST_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      digit_en[NUM_POS-1] && mode_code == '0 |-> seg_out == 7'b1111110); // R6

endmodule

bind digit_scan_driver digit_scan_checker #(
   .NUM_POS (NUM_POS),
   .CNT_POS (CNT_POS),
   .VAL_W   (VAL_W),
   .MODE_W  (MODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_tick (scan_tick),
   .count_val (count_val),
   .mode_code (mode_code),
   .digit_en  (digit_en),
   .seg_out   (seg_out)
);

// File: tb/digit_scan_driver_test.sv
module digit_scan_driver_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scan_tick = 1'b0;
   logic [3:0] count_val = 4'd0;
   logic [2:0] mode_code = 3'd0;
   logic [5:0] digit_en;
   logic [6:0] seg_out;

   int checks = 0;
   int errors = 0;
   int exp_pos = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   digit_scan_driver uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_tick (scan_tick),
      .count_val (count_val),
      .mode_code (mode_code),
      .digit_en  (digit_en),
      .seg_out   (seg_out)
   );

   function automatic logic [6:0] ref_glyph(input logic [3:0] v);
      case (v)
         4'd0: return 7'b1111110;
         4'd1: return 7'b0110000;
         4'd2: return 7'b1101101;
         4'd3: return 7'b1111001;
         4'd4: return 7'b0110011;
         4'd5: return 7'b1011011;
         4'd6: return 7'b1011111;
         4'd7: return 7'b1110000;
         4'd8: return 7'b1111111;
         4'd9: return 7'b1111011;
         default: return 7'b0000000;
      endcase
   endfunction

   function automatic logic [6:0] ref_seg_at(input int pos);
      if (pos < 3) return ref_glyph(count_val);
      return ref_glyph({1'b0, mode_code});
   endfunction

   task automatic check(input string req, input logic [5:0] exp_en, input logic [6:0] exp_seg);
      checks++;
      if (digit_en !== exp_en || seg_out !== exp_seg) begin
         errors++;
         $display("FAIL %s: en=%b seg=%b expected en=%b seg=%b",
                  req, digit_en, seg_out, exp_en, exp_seg);
      end
   endtask

   task automatic check_now(input string req);
      check(req, 6'(1) << exp_pos, ref_seg_at(exp_pos));
   endtask

   task automatic step_tick();
      @(negedge clk) scan_tick = 1'b1;
      @(negedge clk) scan_tick = 1'b0;
      exp_pos = (exp_pos + 1) % 6;
   endtask

   task automatic t_reset();
      count_val = 4'd7;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 during reset", 6'b000001, 7'b1110000);
      rst_n = 1'b1;
      exp_pos = 0;
      @(negedge clk);
      check("R1 after release", 6'b000001, 7'b1110000);
   endtask

   task automatic t_walk();
      count_val = 4'd3;
      mode_code = 3'd5;
      for (int n = 0; n < 13; n++) begin
         step_tick();
         if (exp_pos < 3) check_now("R3 R5 walk count side");
         else             check_now("R3 R6 walk mode side");
      end
   endtask

   task automatic t_hold();
      int start;
      start = exp_pos;
      repeat (20) @(negedge clk);
      check("R4 no tick holds", 6'(1) << start, ref_seg_at(start));
   endtask

   task automatic t_count_codes();
      while (exp_pos != 1) step_tick();
      for (int v = 0; v < 16; v++) begin
         @(negedge clk) count_val = 4'(v);
         #1;
         if (v > 9) check("R8 blank code", 6'b000010, 7'b0000000);
         else       check("R7 glyph table", 6'b000010, ref_glyph(4'(v)));
      end
   endtask

   task automatic t_mode_codes();
      while (exp_pos != 4) step_tick();
      count_val = 4'd8;
      for (int m = 0; m < 8; m++) begin
         @(negedge clk) mode_code = 3'(m);
         #1;
         check("R6 mode zero-extended", 6'b010000, ref_glyph({1'b0, 3'(m)}));
      end
   endtask

   task automatic t_same_cycle();
      count_val = 4'd2;
      mode_code = 3'd1;
      while (exp_pos != 2) step_tick();
      @(negedge clk) begin
         scan_tick = 1'b1;
         mode_code = 3'd6;
         count_val = 4'd12;
      end
      @(negedge clk) scan_tick = 1'b0;
      exp_pos = 3;
      check("R9 cross to mode side", 6'b001000, 7'b1011111);
      step_tick();
      step_tick();
      @(negedge clk) begin
         scan_tick = 1'b1;
         count_val = 4'd9;
      end
      @(negedge clk) scan_tick = 1'b0;
      exp_pos = 0;
      check("R9 wrap with new count", 6'b000001, 7'b1111011);
      @(negedge clk) count_val = 4'd0;
      #1;
      check("R9 data change shows at once", 6'b000001, 7'b1111110);
   endtask

   initial begin
      t_reset();
      t_walk();
      t_hold();
      t_count_codes();
      t_mode_codes();
      t_same_cycle();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule